// File: doc/BRIEF.md
# Register Rename Unit with Free List

This unit is the rename stage in front of a unified physical register file. Each cycle it can take one instruction with two architectural source numbers and one architectural destination. In the same cycle it returns the physical tags the sources currently map to, along with a ready flag for each. For an instruction that writes a register, it also returns a fresh physical destination taken from the free list and the tag that destination used to map to. The reorder buffer keeps that previous tag and sends it back when the instruction commits. At that point the tag returns to the free list.

The unit keeps one ready bit for each physical register. A bit is cleared when its register is allocated and set when a result is written back to that register. At a predicted branch the instruction can ask for a checkpoint. A checkpoint saves the whole rename table and the free-list read position. On a mispredict the saved copy is restored in a single cycle. This hands the registers allocated on the wrong path back to the free list and releases every younger checkpoint. Renaming stalls when an instruction needs a destination and the free list is empty. It also stalls when an instruction asks for a checkpoint and every checkpoint slot is taken, and in any cycle where a restore takes place.

Top module: `rename_core`

## Requirements
- R1: After reset, architectural register i maps to physical tag i and every physical register is ready. The free list holds tags NUM_ARCH to NUM_PHYS-1 and hands them out in increasing order.
- R2: `physA`/`physB` show the current mapping of `srcA`/`srcB` in the same cycle, with no clock edge in between.
- R3: An accepted instruction with `dstArch` not equal to 0 receives the free-list head on `newPhys` and the destination's current mapping on `oldPhys`. From the next cycle, `dstArch` maps to `newPhys`.
- R4: If a source equals the destination of the same instruction, that source reports the old mapping, not the newly allocated tag.
- R5: Architectural register 0 is never renamed. With `dstArch`=0 nothing is allocated and the table does not change. A source of 0 always reads tag 0 and reports ready.
- R6: An allocated tag reads not-ready until a writeback with `wbValid` names it. A source whose tag is written back in the same cycle already reports ready.
- R7: `commitValid` appends `commitTag` to the tail of the free list. Tags are handed out again in first-in, first-out order.
- R8: With the free list empty, an instruction that needs a destination raises `renStall`. It causes no change, and a commit in that same cycle only takes effect from the next cycle.
- R9: An accepted `ckptReq` saves the rename table, including this instruction's own update, and the free-list head. The slot used is reported on `ckptId` and is the lowest-numbered free slot.
- R10: A `ckptReq` while every slot is occupied raises `renStall`.
- R11: A resolve with `resolveMiss` set stalls renaming in that cycle. From the next cycle it restores the table and the free-list head from slot `resolveId`, and it frees that slot and every slot allocated after it.
- R12: A resolve with `resolveMiss` clear frees only slot `resolveId` and leaves the table unchanged.
- R13: A commit that arrives in the same cycle as a restore is kept. Its tag is handed out after the registers reclaimed from the wrong path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| renValid | input | 1 | Instruction present for renaming |
| srcA | input | AW | First architectural source |
| srcB | input | AW | Second architectural source |
| dstArch | input | AW | Architectural destination (0 means none) |
| ckptReq | input | 1 | Instruction is a predicted branch and needs a checkpoint |
| renStall | output | 1 | Instruction not accepted this cycle |
| physA | output | PW | Physical tag of srcA |
| physB | output | PW | Physical tag of srcB |
| readyA | output | 1 | srcA value is available |
| readyB | output | 1 | srcB value is available |
| newPhys | output | PW | Allocated physical destination |
| oldPhys | output | PW | Previous mapping of dstArch |
| ckptId | output | CW | Checkpoint slot given to this branch |
| wbValid | input | 1 | A result is being written back |
| wbTag | input | PW | Physical tag being written back |
| commitValid | input | 1 | An instruction commits and releases a tag |
| commitTag | input | PW | Tag released by the commit |
| resolveValid | input | 1 | A branch resolves |
| resolveMiss | input | 1 | The resolving branch was mispredicted |
| resolveId | input | CW | Checkpoint slot of the resolving branch |

## Verification
The hardest overlap is a mispredict restore in the same cycle as a commit. The restore moves the free-list head backwards while the commit moves the tail forwards, and the table is rewritten while a new instruction is also asking to be renamed. The bench fills both checkpoint slots, renames wrong-path instructions, and then sends the mispredict together with a commit and a rename request. The reference model predicts the exact order in which the reclaimed tags and the committed tag are handed out afterwards. A second overlap is a commit in the same cycle as a stall on an empty free list. That instruction must be refused, and the following one must receive the committed tag.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Strobes sent from the control module to the datapath each cycle.
  typedef struct packed {
    logic alloc;      // pop the free list and write the rename table
    logic snap;       // save the table and head into snapSlot
    logic restore;    // reload the table and head from restoreSlot
    logic commit;     // push the committed tag at the tail
    logic writeback;  // set the ready bit of wbTag
  } renStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_CKPT = 2,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renValid,
  input  logic [AW-1:0] dstArch,
  input  logic          ckptReq,
  input  logic          wbValid,
  input  logic          commitValid,
  input  logic          resolveValid,
  input  logic          resolveMiss,
  input  logic [CW-1:0] resolveId,
  input  logic          freeEmpty,
  output logic          renStall,
  output logic [CW-1:0] snapSlot,
  output renStrobe_t    strobe
);
  logic [NUM_CKPT-1:0] slotValid, slotValidNext;
  logic [NUM_CKPT-1:0] youngQ [NUM_CKPT];
  logic [NUM_CKPT-1:0] youngNext [NUM_CKPT];
  logic                slotFound;
  logic                needDst;
  logic                doRestore;
  logic                accept;

  // Pick the lowest-numbered free checkpoint slot.
  always_comb begin
    slotFound = 1'b0;
    snapSlot  = '0;
    for (int k = NUM_CKPT - 1; k >= 0; k--) begin
      if (!slotValid[k]) begin
        slotFound = 1'b1;
        snapSlot  = CW'(k);
      end
    end
  end

  assign needDst   = (dstArch != '0);
  assign doRestore = resolveValid && resolveMiss;
  assign renStall  = doRestore ||
                     (renValid && ((needDst && freeEmpty) || (ckptReq && !slotFound)));
  assign accept    = renValid && !renStall;

  always_comb begin
    strobe           = '0;
    strobe.alloc     = accept && needDst;
    strobe.snap      = accept && ckptReq;
    strobe.restore   = doRestore;
    strobe.commit    = commitValid;
    strobe.writeback = wbValid;
  end

  // Slot occupancy and the "allocated after" relation between slots.
  always_comb begin
    slotValidNext = slotValid;
    youngNext     = youngQ;
    if (resolveValid) begin
      slotValidNext[resolveId] = 1'b0;
      if (resolveMiss) slotValidNext = slotValidNext & ~youngQ[resolveId];
    end
    if (strobe.snap) begin
      for (int k = 0; k < NUM_CKPT; k++) begin
        if (slotValidNext[k]) youngNext[k][snapSlot] = 1'b1;
      end
      youngNext[snapSlot]     = '0;
      slotValidNext[snapSlot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int k = 0; k < NUM_CKPT; k++) youngQ[k] <= '0;
    end else begin
      slotValid <= slotValidNext;
      youngQ    <= youngNext;
    end
  end

  AST_SLOT_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && ckptReq && (&slotValid)) |-> renStall); // R10
  AST_RESOLVE_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |-> slotValid[resolveId]); // R12
  AST_SNAP_CLAIMS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.snap && !doRestore) |=> slotValid[$past(snapSlot)]); // R9
endmodule

// File: rtl/rename_dpath.sv
module rename_dpath
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_CKPT = 2,
  localparam int AW   = $clog2(NUM_ARCH),
  localparam int PW   = $clog2(NUM_PHYS),
  localparam int PTRW = PW + 1,
  localparam int CW   = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int POOL = NUM_PHYS - NUM_ARCH
) (
  input  logic          clk,
  input  logic          rstN,
  input  renStrobe_t    strobe,
  input  logic [AW-1:0] srcA,
  input  logic [AW-1:0] srcB,
  input  logic [AW-1:0] dstArch,
  input  logic [PW-1:0] wbTag,
  input  logic [PW-1:0] commitTag,
  input  logic [CW-1:0] snapSlot,
  input  logic [CW-1:0] restoreSlot,
  output logic [PW-1:0] physA,
  output logic [PW-1:0] physB,
  output logic          readyA,
  output logic          readyB,
  output logic [PW-1:0] newPhys,
  output logic [PW-1:0] oldPhys,
  output logic          freeEmpty
);
  logic [PW-1:0]   mapQ     [NUM_ARCH];
  logic [PW-1:0]   mapNext  [NUM_ARCH];
  logic [PW-1:0]   freeMem  [NUM_PHYS];
  logic [PW-1:0]   snapMap  [NUM_CKPT][NUM_ARCH];
  logic [PTRW-1:0] snapHead [NUM_CKPT];
  logic [PTRW-1:0] headQ, tailQ, headNext, freeCount, restoreHead;
  logic [NUM_PHYS-1:0] readyQ, readyNext;

  // Two source read ports, built from one template.
  logic [1:0][AW-1:0] srcArr;
  logic [1:0][PW-1:0] physArr;
  logic [1:0]         readyArr;
  assign srcArr = {srcB, srcA};

  for (genvar p = 0; p < 2; p++) begin : gRead
    assign physArr[p]  = mapQ[srcArr[p]];
    assign readyArr[p] = (srcArr[p] == '0) || readyQ[physArr[p]] ||
                         (strobe.writeback && (wbTag == physArr[p]));
  end

  assign physA  = physArr[0];
  assign physB  = physArr[1];
  assign readyA = readyArr[0];
  assign readyB = readyArr[1];

  assign newPhys     = freeMem[headQ[PW-1:0]];
  assign oldPhys     = mapQ[dstArch];
  assign freeEmpty   = (headQ == tailQ);
  assign freeCount   = tailQ - headQ;
  assign headNext    = headQ + PTRW'(strobe.alloc);
  assign restoreHead = snapHead[restoreSlot];

  always_comb begin
    mapNext = mapQ;
    if (strobe.alloc) mapNext[dstArch] = newPhys;
  end

  always_comb begin
    readyNext = readyQ;
    if (strobe.writeback) readyNext[wbTag] = 1'b1;
    if (strobe.alloc) readyNext[newPhys] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_ARCH; a++) mapQ[a] <= PW'(a);
      for (int i = 0; i < NUM_PHYS; i++) freeMem[i] <= (i < POOL) ? PW'(NUM_ARCH + i) : '0;
      headQ  <= '0;
      tailQ  <= PTRW'(POOL);
      readyQ <= '1;
    end else begin
      readyQ <= readyNext;
      if (strobe.commit) begin
        freeMem[tailQ[PW-1:0]] <= commitTag;
        tailQ <= tailQ + 1'b1;
      end
      if (strobe.restore) begin
        mapQ  <= snapMap[restoreSlot];
        headQ <= restoreHead;
      end else begin
        mapQ  <= mapNext;
        headQ <= headNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_CKPT; s++) begin
        for (int a = 0; a < NUM_ARCH; a++) snapMap[s][a] <= PW'(a);
        snapHead[s] <= '0;
      end
    end else if (strobe.snap) begin
      snapMap[snapSlot]  <= mapNext;
      snapHead[snapSlot] <= headNext;
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> !freeEmpty); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= PTRW'(POOL)); // R7
  AST_NEW_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> !readyQ[$past(newPhys)]); // R6
  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rstN)
    mapQ[0] == '0); // R5
  AST_NO_ALLOC_ON_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restore |-> !strobe.alloc && !strobe.snap); // R11
  AST_RESTORE_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restore |=> headQ == $past(restoreHead)); // R11
endmodule

// File: rtl/rename_core.sv
module rename_core
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_CKPT = 2,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renValid,
  input  logic [AW-1:0] srcA,
  input  logic [AW-1:0] srcB,
  input  logic [AW-1:0] dstArch,
  input  logic          ckptReq,
  output logic          renStall,
  output logic [PW-1:0] physA,
  output logic [PW-1:0] physB,
  output logic          readyA,
  output logic          readyB,
  output logic [PW-1:0] newPhys,
  output logic [PW-1:0] oldPhys,
  output logic [CW-1:0] ckptId,
  input  logic          wbValid,
  input  logic [PW-1:0] wbTag,
  input  logic          commitValid,
  input  logic [PW-1:0] commitTag,
  input  logic          resolveValid,
  input  logic          resolveMiss,
  input  logic [CW-1:0] resolveId
);
  renStrobe_t    strobe;
  logic          freeEmpty;
  logic [CW-1:0] snapSlot;

  rename_ctrl #(.NUM_ARCH(NUM_ARCH), .NUM_CKPT(NUM_CKPT)) uCtrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .dstArch(dstArch),
    .ckptReq(ckptReq), .wbValid(wbValid), .commitValid(commitValid),
    .resolveValid(resolveValid), .resolveMiss(resolveMiss), .resolveId(resolveId),
    .freeEmpty(freeEmpty), .renStall(renStall), .snapSlot(snapSlot), .strobe(strobe)
  );

  rename_dpath #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcA(srcA), .srcB(srcB),
    .dstArch(dstArch), .wbTag(wbTag), .commitTag(commitTag), .snapSlot(snapSlot),
    .restoreSlot(resolveId), .physA(physA), .physB(physB), .readyA(readyA),
    .readyB(readyB), .newPhys(newPhys), .oldPhys(oldPhys), .freeEmpty(freeEmpty)
  );

  assign ckptId = snapSlot;
endmodule

// File: tb/sim_rename_core.sv
module sim_rename_core;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic renValid = 0, ckptReq = 0, wbValid = 0, commitValid = 0;
  logic resolveValid = 0, resolveMiss = 0;
  logic [2:0] srcA = 0, srcB = 0, dstArch = 0;
  logic [3:0] wbTag = 0, commitTag = 0;
  logic [0:0] resolveId = 0;
  logic renStall, readyA, readyB;
  logic [3:0] physA, physB, newPhys, oldPhys;
  logic [0:0] ckptId;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rename_core #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC)) u0 (
    .clk(clk), .rstN(rstN), .renValid(renValid), .srcA(srcA), .srcB(srcB),
    .dstArch(dstArch), .ckptReq(ckptReq), .renStall(renStall), .physA(physA),
    .physB(physB), .readyA(readyA), .readyB(readyB), .newPhys(newPhys),
    .oldPhys(oldPhys), .ckptId(ckptId), .wbValid(wbValid), .wbTag(wbTag),
    .commitValid(commitValid), .commitTag(commitTag), .resolveValid(resolveValid),
    .resolveMiss(resolveMiss), .resolveId(resolveId)
  );

  typedef struct {
    bit    live;
    int    pa, pb, ra, rb, np, op, stall, ck, cid;
    string req;
  } exp_t;

  exp_t expQ[$];
  int   retireQ[$];
  int   checks = 0, errors = 0;

  // Reference state, derived from the requirements.
  int mMap [NA];
  bit mReady [NP];
  int fl [NP];
  int fh, ft;
  bit sv [NC];
  int sMap [NC][NA];
  int sH [NC];
  bit yng [NC][NC];
  int wrongAllocs;

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: compares after the driver has set the inputs, before the next edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD / 4);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.req, "renStall", int'(renStall), e.stall);
        if (e.live) begin
          chk(e.req, "physA", int'(physA), e.pa);
          chk(e.req, "physB", int'(physB), e.pb);
          chk(e.req, "readyA", int'(readyA), e.ra);
          chk(e.req, "readyB", int'(readyB), e.rb);
          chk(e.req, "oldPhys", int'(oldPhys), e.op);
          if (e.np >= 0) chk(e.req, "newPhys", int'(newPhys), e.np);
          if (e.ck != 0) chk(e.req, "ckptId", int'(ckptId), e.cid);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus, queues the expectation, advances the model.
  task automatic step(input bit v, input int a, input int b, input int d, input bit ck,
                      input bit wv, input int wt, input bit cv,
                      input bit rv, input bit rm, input int rid, input string req);
    exp_t e;
    int fs, ct;
    bit miss, acc, needD;
    @(negedge clk);
    ct = 0;
    if (cv) ct = retireQ.pop_front();
    renValid = v; srcA = 3'(a); srcB = 3'(b); dstArch = 3'(d); ckptReq = ck;
    wbValid = wv; wbTag = 4'(wt); commitValid = cv; commitTag = 4'(ct);
    resolveValid = rv; resolveMiss = rm; resolveId = 1'(rid);
    fs = -1;
    for (int k = NC - 1; k >= 0; k--) if (!sv[k]) fs = k;
    needD = (d != 0);
    miss  = rv && rm;
    e.req   = req;
    e.stall = int'(miss || (v && ((needD && ft == fh) || (ck && fs < 0))));
    acc     = v && (e.stall == 0);
    e.live  = (e.stall == 0);
    e.pa = mMap[a];
    e.pb = mMap[b];
    e.ra = int'((a == 0) || mReady[e.pa] || (wv && wt == e.pa));
    e.rb = int'((b == 0) || mReady[e.pb] || (wv && wt == e.pb));
    e.op = mMap[d];
    e.np = (v && needD) ? fl[fh % NP] : -1;
    e.ck = int'(acc && ck);
    e.cid = fs;
    expQ.push_back(e);
    @(posedge clk);
    #1;
    if (wv) mReady[wt] = 1'b1;
    if (cv) begin fl[ft % NP] = ct; ft++; end
    if (miss) begin
      mMap = sMap[rid];
      fh = sH[rid];
      sv[rid] = 1'b0;
      for (int j = 0; j < NC; j++) if (yng[rid][j]) sv[j] = 1'b0;
    end else if (rv) begin
      sv[rid] = 1'b0;
    end
    if (acc) begin
      if (needD) begin
        retireQ.push_back(mMap[d]);
        mReady[fl[fh % NP]] = 1'b0;
        mMap[d] = fl[fh % NP];
        fh++;
        wrongAllocs++;
      end
      if (ck) begin
        for (int k = 0; k < NC; k++) if (sv[k] && k != fs) yng[k][fs] = 1'b1;
        for (int j = 0; j < NC; j++) yng[fs][j] = 1'b0;
        sv[fs] = 1'b1;
        sMap[fs] = mMap;
        sH[fs] = fh;
      end
    end
    renValid = 0; ckptReq = 0; wbValid = 0; commitValid = 0; resolveValid = 0; resolveMiss = 0;
  endtask

  task automatic ren(input int a, input int b, input int d, input bit ck, input string req);
    step(1, a, b, d, ck, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < NA; a++) mMap[a] = a;
    for (int i = 0; i < NP; i++) mReady[i] = 1'b1;
    for (int i = 0; i < NP - NA; i++) fl[i] = NA + i;
    fh = 0; ft = NP - NA;
    for (int k = 0; k < NC; k++) begin
      sv[k] = 0; sH[k] = 0;
      for (int j = 0; j < NC; j++) yng[k][j] = 0;
      for (int a = 0; a < NA; a++) sMap[k][a] = a;
    end
    wrongAllocs = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset mapping and readiness, R5 source zero
    step(0, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R4 source equal to destination, R3 first allocation is tag 8
    ren(1, 2, 1, 0, "R4");
    // R2 same-cycle mapping, R6 new tag not ready
    ren(1, 1, 3, 0, "R6");
    // R5 destination zero allocates nothing
    ren(0, 3, 0, 0, "R5");
    ren(3, 4, 4, 0, "R3");
    // R6 same-cycle writeback bypass on source 1
    step(1, 1, 2, 5, 0, 1, 8, 0, 0, 0, 0, "R6");
    ren(1, 5, 2, 0, "R2");
    // R7 commit returns a tag to the tail
    step(0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) ren(2, 6, 6, 0, "R7");
    // R8 empty list stalls, commit the same cycle takes effect next cycle
    ren(6, 6, 6, 0, "R8");
    step(1, 6, 2, 6, 0, 0, 0, 1, 0, 0, 0, "R8");
    ren(6, 2, 7, 0, "R7");
    for (int i = 0; i < 5; i++) step(0, 7, 6, 0, 0, 0, 0, 1, 0, 0, 0, "R7");

    // R9 checkpoints take the lowest free slot and include their own update
    ren(1, 2, 5, 1, "R9");
    wrongAllocs = 0;
    ren(5, 5, 5, 0, "R9");
    ren(5, 3, 3, 0, "R9");
    ren(2, 3, 2, 1, "R9");
    // R10 all slots taken
    ren(1, 1, 1, 1, "R10");
    // R12 correct resolve frees only slot 1
    step(0, 5, 2, 0, 0, 0, 0, 0, 1, 0, 1, "R12");
    ren(3, 2, 1, 1, "R12");
    ren(1, 1, 1, 1, "R10");
    // R11 + R13 mispredict on slot 0 with a commit and a rename request in the same cycle
    repeat (wrongAllocs) void'(retireQ.pop_back());
    step(1, 5, 3, 4, 0, 0, 0, 1, 1, 1, 0, "R13");
    // R11 table restored, reclaimed tags handed out, younger slot freed
    ren(5, 3, 2, 1, "R11");
    ren(2, 1, 6, 0, "R11");
    ren(1, 6, 4, 1, "R11");
    ren(4, 4, 3, 0, "R13");
    ren(3, 3, 7, 0, "R13");
    // R6 writeback of an allocated tag makes it ready on the next read
    step(0, 7, 3, 0, 0, 1, mMap[7], 0, 0, 0, 0, "R6");
    step(0, 7, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R6");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule